// File: doc/BRIEF.md
# Channel Enable Gating with Parallel Override and Thermal Restart

This block decides, every clock, which of eight low-side output channels may conduct. Each channel has a command bit written by a serial front end. The first four channels also have a direct input, which a timer or PWM source can toggle at speed. The direct input and the command bit are combined with an AND, so a cleared command bit always keeps the channel off. A polarity select input chooses whether the direct inputs are active high or active low. The direct inputs and the polarity select come from outside the clock domain, so both are resynchronised.

Three conditions override the request. An active-low reset clears every enable at once. An undervoltage input blanks all channels while it is asserted. A per-channel over-temperature flag puts that channel into a restart pattern: it may conduct during only one phase of a 16-phase cycle that advances on a slow tick, and it returns to normal operation when the flag clears. The slow tick period is a run-time input in clock cycles.

Top module: `chg_gate_top`

## Requirements
- R1: Channel k+1 (k = 0..3) is enabled only when cmd_bits[k] is 1 and par_in[k] is at its active level. A cleared command bit keeps the channel off whatever the direct input does.
- R2: When pol_sel is 1, par_in is active high. When pol_sel is 0, par_in is active low. Changes on pol_sel and par_in reach chan_en on the third rising clock edge after they change, because of two synchroniser stages and the output register.
- R3: Channels 5 to 8 (cmd_bits[7:4]) follow their command bits, where 1 means on and 0 means off. A command change appears on chan_en after one rising edge.
- R4: While rst_n is low, chan_en is all zeros. This takes effect without waiting for a clock edge.
- R5: When uv_force is high at a rising edge, chan_en is all zeros after that edge.
- R6: While ot_flag[i] stays high, channel i is enabled for exactly P cycles in every 16*P consecutive cycles, where P is tick_period. A tick_period of 0 acts as 1. This holds provided the channel is requested on throughout.
- R7: One cycle after ot_flag[i] falls, the restart mode ends. Two rising edges after the fall, chan_en[i] again equals the plain request.
- R8: Bit i of cmd_bits, ot_flag and chan_en all belong to channel i+1. The restart mode or a request on one channel never changes any other channel's enable.
- R9: The restart pattern begins in an off phase. Two rising edges after ot_flag[i] rises, chan_en[i] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset; forces all channels off |
| cmd_bits | input | 8 | Latched serial command byte; bit i requests channel i+1 on |
| par_in | input | 4 | Direct inputs for channels 1 to 4, asynchronous |
| pol_sel | input | 1 | Direct input polarity: 1 active high, 0 active low |
| uv_force | input | 1 | Undervoltage indication; blanks all channels |
| ot_flag | input | 8 | Per-channel over-temperature flag |
| tick_period | input | 16 | Slow tick period in clock cycles (0 behaves as 1) |
| chan_en | output | 8 | Registered channel enables |

## Verification
The bench sweeps every combination of polarity, the four direct inputs and the full command byte. A design that let a direct input win over a cleared command bit, or that inverted the wrong polarity, shows up as a mismatch on the first four channels. Latency is checked edge by edge. A missing or extra synchroniser stage moves the polarity change by one cycle, and an unregistered override path changes the undervoltage timing. In restart mode, the on-cycles are counted over exact 16-phase windows for two tick periods, one of them the zero period. A phase counter that starts in the on phase, skips the tick, or leaks into neighbouring channels gives the wrong count or disturbs other bits.

// File: rtl/chg_pkg.sv
package chg_pkg;
  localparam int unsigned CH_N     = 8;
  localparam int unsigned PAR_N    = 4;
  localparam int unsigned TICK_W   = 16;
  localparam int unsigned PHASE_W  = 4;

  // Direct input seen through the polarity select: 1 means "asks for on".
  function automatic logic par_active(input logic pol, input logic raw);
    return pol ? raw : ~raw;
  endfunction

  // Terminal count of the tick divider; a zero period behaves as one.
  function automatic logic [TICK_W-1:0] tick_last(input logic [TICK_W-1:0] per);
    return (per == '0) ? '0 : per - 1'b1;
  endfunction
endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/chg_tick.sv
module chg_tick
  import chg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] period,
  output logic              tick
);
  logic [TICK_W-1:0] cnt_q;
  logic [TICK_W-1:0] last_c;

  assign last_c = tick_last(period);
  assign tick   = (cnt_q >= last_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // R6: after a tick the divider restarts from zero
  tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/chg_therm.sv
module chg_therm
  import chg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ot_flag,
  input  logic tick,
  output logic allow,
  output logic in_mode
);
  localparam logic [PHASE_W-1:0] START_PH = PHASE_W'(1);

  logic               mode_q;
  logic [PHASE_W-1:0] phase_q;
  logic               past_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      phase_q   <= START_PH;
      past_ok_q <= 1'b0;
    end else begin
      mode_q    <= ot_flag;
      past_ok_q <= 1'b1;
      if (!ot_flag)  phase_q <= START_PH;
      else if (tick) phase_q <= phase_q + 1'b1;
    end
  end

  assign allow   = ~mode_q | (phase_q == '0);
  assign in_mode = mode_q;

  // R6: the restart phase only moves on a slow tick
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && $past(ot_flag) && !$past(tick)) |-> $stable(phase_q));

  // R9: a channel entering restart mode starts in an off phase
  entry_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q) |-> !allow);
endmodule

// File: rtl/chg_gate_top.sv
module chg_gate_top
  import chg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_N-1:0]   cmd_bits,
  input  logic [PAR_N-1:0]  par_in,
  input  logic              pol_sel,
  input  logic              uv_force,
  input  logic [CH_N-1:0]   ot_flag,
  input  logic [TICK_W-1:0] tick_period,
  output logic [CH_N-1:0]   chan_en
);
  logic [PAR_N-1:0] par_s;
  logic             pol_s;
  logic             tick;
  logic [CH_N-1:0]  par_ok;
  logic [CH_N-1:0]  therm_ok;
  logic [CH_N-1:0]  therm_mode;
  logic [CH_N-1:0]  req_c;
  logic [CH_N-1:0]  en_d;
  logic [CH_N-1:0]  en_q;
  logic [1:0]       age_q;

  chg_sync #(.W(PAR_N), .STAGES(2), .RST_VAL('0)) i_par_sync (
    .clk(clk), .rst_n(rst_n), .d(par_in), .q(par_s));

  chg_sync #(.W(1), .STAGES(2), .RST_VAL(1'b1)) i_pol_sync (
    .clk(clk), .rst_n(rst_n), .d(pol_sel), .q(pol_s));

  chg_tick i_tick (
    .clk(clk), .rst_n(rst_n), .period(tick_period), .tick(tick));

  generate
    for (genvar i = 0; i < CH_N; i++) begin : g_ch
      if (i < PAR_N) begin : g_par
        assign par_ok[i] = par_active(pol_s, par_s[i]);
      end else begin : g_ser
        assign par_ok[i] = 1'b1;
      end
      chg_therm i_therm (
        .clk(clk), .rst_n(rst_n), .ot_flag(ot_flag[i]), .tick(tick),
        .allow(therm_ok[i]), .in_mode(therm_mode[i]));
    end
  endgenerate

  assign req_c = cmd_bits & par_ok;
  assign en_d  = uv_force ? '0 : (req_c & therm_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      age_q <= '0;
    end else begin
      en_q  <= en_d;
      if (age_q != 2'd3) age_q <= age_q + 1'b1;
    end
  end

  assign chan_en = en_q;

  // R4: reset holds every enable low
  reset_off_chk: assert property (@(posedge clk) !rst_n |-> (chan_en == '0));

  // R5: undervoltage at an edge blanks all channels after it
  uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && $past(uv_force)) |-> (chan_en == '0));

  // R1
  cmd_zero_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0) |-> ((chan_en & ~$past(cmd_bits)) == '0));

  // R3
  serial_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && !$past(uv_force) && ($past(therm_mode[CH_N-1:PAR_N]) == '0))
      |-> (chan_en[CH_N-1:PAR_N] == $past(cmd_bits[CH_N-1:PAR_N])));

  // R2
  pol_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (pol_s == $past(pol_sel, 2)));
endmodule

// File: tb/test_chg_gate_top.sv
module test_chg_gate_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cmd_bits;
  logic [3:0]  par_in;
  logic        pol_sel;
  logic        uv_force;
  logic [7:0]  ot_flag;
  logic [15:0] tick_period;
  logic [7:0]  chan_en;

  int vec_n  = 0;
  int miss_n = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  chg_gate_top i_chg_gate_top (
    .clk(clk), .rst_n(rst_n), .cmd_bits(cmd_bits), .par_in(par_in),
    .pol_sel(pol_sel), .uv_force(uv_force), .ot_flag(ot_flag),
    .tick_period(tick_period), .chan_en(chan_en));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec_n++;
    if (act !== exp) begin
      miss_n++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [7:0] c, input logic [3:0] p, input logic pol);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) begin
      if (b >= 4) r[b] = c[b];
      else        r[b] = c[b] && (p[b] == pol);
    end
    return r;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vec_n++;
    miss_n++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int ones;
    rst_n = 1'b0; cmd_bits = 8'hFF; par_in = 4'hF; pol_sel = 1'b1;
    uv_force = 1'b0; ot_flag = 8'h00; tick_period = 16'd3;
    repeat (3) @(negedge clk);
    check("R4 reset state", chan_en, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 R3 R8: full sweep of polarity, direct inputs and command byte
    for (int pl = 0; pl < 2; pl++)
      for (int p = 0; p < 16; p++)
        for (int c = 0; c < 256; c++) begin
          pol_sel = pl[0]; par_in = p[3:0]; cmd_bits = c[7:0];
          repeat (3) @(negedge clk);
          check("R1 R2 R3 sweep", chan_en, model(c[7:0], p[3:0], pl[0]));
        end

    // R3: one-edge latency on the serial path
    pol_sel = 1'b1; par_in = 4'hF; cmd_bits = 8'hF0;
    repeat (4) @(negedge clk);
    cmd_bits = 8'h3C;
    @(negedge clk);
    check("R3 latency", chan_en, 8'h3C);

    // R2: polarity flip lands on the third edge
    cmd_bits = 8'hFF;
    repeat (3) @(negedge clk);
    pol_sel = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 before third edge", chan_en, 8'hFF);
    @(negedge clk);
    check("R2 third edge", chan_en, 8'hF0);
    pol_sel = 1'b1;
    repeat (3) @(negedge clk);

    // R5: undervoltage blanking
    uv_force = 1'b1;
    @(negedge clk);
    check("R5 uv on", chan_en, 8'h00);
    cmd_bits = 8'hA5;
    @(negedge clk);
    check("R5 uv hold", chan_en, 8'h00);
    uv_force = 1'b0;
    @(negedge clk);
    check("R5 uv release", chan_en, 8'hA5);

    // R4: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R4 async reset", chan_en, 8'h00);
    @(negedge clk);
    rst_n = 1'b1; cmd_bits = 8'hFF; par_in = 4'hF; pol_sel = 1'b1;
    repeat (4) @(negedge clk);
    check("R4 recovery", chan_en, 8'hFF);

    // R9 R6 R8: restart mode on channels 1 and 5
    ot_flag = 8'h11;
    repeat (2) @(negedge clk);
    check("R9 entry off", chan_en & 8'h11, 8'h00);
    repeat (200) @(negedge clk);
    ones = 0;
    for (int t = 0; t < 96; t++) begin
      @(negedge clk);
      ones += int'(chan_en[4]) + int'(chan_en[0]);
      if ((chan_en & 8'hEE) != 8'hEE) check("R8 isolation", chan_en & 8'hEE, 8'hEE);
    end
    check("R6 duty P=3", ones, 12);
    check("R8 neighbours", chan_en & 8'hEE, 8'hEE);

    // R1: cleared command bit wins during restart mode
    cmd_bits = 8'hEF;
    ones = 0;
    for (int t = 0; t < 96; t++) begin
      @(negedge clk);
      ones += int'(chan_en[4]);
    end
    check("R1 off wins in restart", ones, 0);
    cmd_bits = 8'hFF;

    // R7: exit restart mode
    ot_flag = 8'h00;
    repeat (2) @(negedge clk);
    check("R7 exit", chan_en, 8'hFF);

    // R6: zero period behaves as one
    tick_period = 16'd0;
    ot_flag = 8'h80;
    repeat (40) @(negedge clk);
    ones = 0;
    for (int t = 0; t < 32; t++) begin
      @(negedge clk);
      ones += int'(chan_en[7]);
    end
    check("R6 duty P=0", ones, 2);
    ot_flag = 8'h00;
    repeat (2) @(negedge clk);
    check("R7 exit P=0", chan_en, 8'hFF);

    finish_run();
  end
endmodule